// File: doc/BRIEF.md
# Prioritised Split-Transaction Data-Phase Scheduler

This block is the host side of a pipelined, split-transaction graphics port. The card presents one request per clock while its request strobe is high. Each request carries a direction, a priority, a length of one to four beats and a start address. The host keeps four queues, one for each pair of direction and priority, and each queue keeps arrival order. Whenever the data bus is free, the host picks one queue that has work ready. It announces the next data phase by raising the grant for one cycle, together with a 3-bit status code that names the chosen queue.

The data phase starts in the cycle after the grant. It always occupies a slot of four beats. For a read, the host raises target-ready and drives the data of the oldest request in that queue. For a write, it captures the card's data and commits each real beat to memory. Beats past the request's length are dummy beats with every byte enable low. The first two beats of a slot always complete. From the third beat on, a beat completes only in a cycle where the card's initiator-ready is high.

Memory is modelled as a fixed-latency responder. The read word at an address is a fixed hash of that address, and read data becomes available a set number of cycles after a request reaches the head of its queue.

Top module: `split_txn_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, grant, target-ready and the memory write strobe are low, all read byte enables are zero and the status code is 3'b111.
- R2: The status code is 3'b111 whenever the grant is low. With the grant high it is {1'b0, dir, pri}, where dir=1 means write, pri=1 means high priority, and bit 2 is always 0. A grant is raised only for a queue that holds a ready request.
- R3: Each of the four queues holds at most DEPTH requests. A request presented while its queue is full is discarded and never gets a data phase.
- R4: Within one queue, requests get data phases in the order they arrived, and each request gets exactly one.
- R5: A read request becomes ready RD_LAT cycles after it reaches the head of its queue. A read presented to an idle, empty block is granted RD_LAT+2 cycles after the cycle it is presented, and a write is granted 2 cycles after.
- R6: Among ready queues the choice order is high read, high write, low read, low write.
- R7: Target-ready is high from the cycle after the grant until the fourth beat completes. Read beat k (0..3, for k below the length) drives byte enables all ones and data mem_word(addr+k), where mem_word(a) = (a*32'h9E3779B1) ^ 32'h5A5A0F0F on a zero-extended 16-bit address.
- R8: Beats 0 and 1 complete unconditionally. Beats 2 and 3 complete only in a cycle with irdy_in high, and the bus holds the beat otherwise.
- R9: Read beats at or past the request length drive byte enables 0 and data 0. Write beats at or past the length commit nothing.
- R10: A completed write beat k below the length raises the memory write strobe in the next cycle, with address addr+k and the data the card drove in the completing cycle.
- R11: Grant and target-ready are never high in the same cycle, and a new grant never appears while a data phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_in | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | Request direction, 1 = write |
| req_hi | input | 1 | Request priority, 1 = high |
| req_len_m1 | input | 2 | Request length minus one, in beats |
| req_addr | input | AW | Request start address |
| irdy_in | input | 1 | Card ready, gates beats 2 and 3 |
| wr_data_in | input | DW | Write data from the card |
| gnt_out | output | 1 | Grant, announces the next data phase |
| st_out | output | 3 | Status code naming the chosen queue |
| trdy_out | output | 1 | Target ready during a data phase |
| rd_data_out | output | DW | Read beat data |
| rd_be_out | output | DW/8 | Read beat byte enables |
| mem_we_out | output | 1 | Memory write commit strobe |
| mem_waddr_out | output | AW | Memory write address |
| mem_wdata_out | output | DW | Memory write data |

## Verification
The bench builds the block with DEPTH=4, RD_LAT=3, AW=16 and DW=32. With a depth of four, a queue fills within a few cycles while a stalled third beat keeps the bus busy, so the discard path is reached on purpose. A latency of three keeps a read waiting long enough that several queues become ready together, which exercises the full priority order. Random request lengths of one to four beats cover every amount of padding in both directions.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GRANT = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  localparam logic [2:0] ST_NONE = 3'b111;

  // status code for a queue index {dir, pri}
  function automatic logic [2:0] st_code(input logic [1:0] qidx);
    return {1'b0, qidx};
  endfunction

  // fixed memory content model: hash of the word address
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // a beat carries real data when its index does not exceed len-1
  function automatic logic beat_is_real(input logic [1:0] beat, input logic [1:0] len_m1);
    return beat <= len_m1;
  endfunction

endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= next_ptr(wr_ptr);
      end
      if (do_pop) rd_ptr <= next_ptr(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH)));
  a_r2_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sched_head_timer.sv
module sched_head_timer #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clear,
  output logic ready
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!active || clear) cnt <= '0;
    else if (cnt < CW'(LAT))   cnt <= cnt + 1'b1;
  end

  assign ready = active && (cnt == CW'(LAT));

  // R5: a head that has just appeared is never ready at once
  a_r5_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> !ready);
  a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ready);
endmodule

// File: rtl/sched_arbiter.sv
module sched_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ready,
  output logic       valid,
  output logic [1:0] qsel
);
  // queue index = {dir, pri}; order: hi read(1), hi write(3), lo read(0), lo write(2)
  always_comb begin
    valid = 1'b1;
    if      (ready[1]) qsel = 2'd1;
    else if (ready[3]) qsel = 2'd3;
    else if (ready[0]) qsel = 2'd0;
    else if (ready[2]) qsel = 2'd2;
    else begin
      qsel  = 2'd0;
      valid = 1'b0;
    end
  end

  a_r6_hi_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    ready[1] |-> (valid && qsel == 2'd1));
  a_r6_lo_write_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && qsel == 2'd2) |-> (ready == 4'b0100));
endmodule

// File: rtl/split_txn_sched.sv
module split_txn_sched #(
  parameter int DEPTH  = 4,
  parameter int RD_LAT = 3,
  parameter int AW     = 16,
  parameter int DW     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pipe_in,
  input  logic            req_write,
  input  logic            req_hi,
  input  logic [1:0]      req_len_m1,
  input  logic [AW-1:0]   req_addr,
  input  logic            irdy_in,
  input  logic [DW-1:0]   wr_data_in,
  output logic            gnt_out,
  output logic [2:0]      st_out,
  output logic            trdy_out,
  output logic [DW-1:0]   rd_data_out,
  output logic [DW/8-1:0] rd_be_out,
  output logic            mem_we_out,
  output logic [AW-1:0]   mem_waddr_out,
  output logic [DW-1:0]   mem_wdata_out
);
  import sched_pkg::*;

  localparam int NQ  = 4;
  localparam int EW  = AW + 2;
  localparam int BEW = DW / 8;

  logic [NQ-1:0] q_push, q_pop, q_empty, q_ready;
  logic [EW-1:0] q_dout [NQ];
  logic          pick_valid, launch, adv, real_beat, is_write;
  logic [1:0]    pick_q;

  phase_e        ph;
  logic [1:0]    sel_q, beat, cur_len;
  logic [AW-1:0] cur_addr;

  // ---------------- queues, one per {dir, pri} ----------------
  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_q
      assign q_push[g] = pipe_in && ({req_write, req_hi} == 2'(g));
      assign q_pop[g]  = launch && (pick_q == 2'(g));

      sched_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push[g]), .pop(q_pop[g]),
        .din({req_addr, req_len_m1}), .dout(q_dout[g]), .empty(q_empty[g])
      );

      if (g >= 2) begin : g_wr
        assign q_ready[g] = !q_empty[g];
      end else begin : g_rd
        sched_head_timer #(.LAT(RD_LAT)) u_tmr (
          .clk(clk), .rst_n(rst_n), .active(!q_empty[g]),
          .clear(q_pop[g]), .ready(q_ready[g])
        );
      end
    end
  endgenerate

  sched_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .ready(q_ready), .valid(pick_valid), .qsel(pick_q)
  );

  // ---------------- phase engine ----------------
  assign launch    = (ph == PH_IDLE) && pick_valid;
  assign adv       = (ph == PH_DATA) && (!beat[1] || irdy_in);
  assign real_beat = beat_is_real(beat, cur_len);
  assign is_write  = sel_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      sel_q    <= '0;
      beat     <= '0;
      cur_len  <= '0;
      cur_addr <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (launch) begin
          ph       <= PH_GRANT;
          sel_q    <= pick_q;
          cur_addr <= q_dout[pick_q][EW-1:2];
          cur_len  <= q_dout[pick_q][1:0];
          beat     <= '0;
        end
        PH_GRANT: ph <= PH_DATA;
        PH_DATA: if (adv) begin
          if (beat == 2'd3) ph <= PH_IDLE;
          beat <= beat + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // ---------------- memory write commit ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we_out    <= 1'b0;
      mem_waddr_out <= '0;
      mem_wdata_out <= '0;
    end else begin
      mem_we_out <= adv && is_write && real_beat;
      if (adv && is_write && real_beat) begin
        mem_waddr_out <= cur_addr + AW'(beat);
        mem_wdata_out <= wr_data_in;
      end
    end
  end

  // ---------------- bus outputs ----------------
  logic rd_beat;
  assign rd_beat     = (ph == PH_DATA) && !is_write && real_beat;
  assign gnt_out     = (ph == PH_GRANT);
  assign st_out      = gnt_out ? st_code(sel_q) : ST_NONE;
  assign trdy_out    = (ph == PH_DATA);
  assign rd_be_out   = rd_beat ? {BEW{1'b1}} : '0;
  assign rd_data_out = rd_beat ? DW'(mem_word(32'(cur_addr + AW'(beat)))) : '0;

  a_r11_gnt_trdy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_out && trdy_out));
  a_r7_phase_follows: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_out |=> trdy_out);
  a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_out |-> (st_out == 3'b111));
  a_r2_grant_code: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_out |-> !st_out[2]);
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_out && beat[1] && !irdy_in) |=> (trdy_out && $stable(rd_data_out) && $stable(rd_be_out)));
  a_r9_be_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_be_out == '0) || (rd_be_out == {BEW{1'b1}}));
  a_r10_commit_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_out |-> $past(trdy_out));
endmodule

// File: tb/split_txn_sched_tb_top.sv
module split_txn_sched_tb_top;
  localparam int DEPTH = 4, LAT = 3, AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pipe_in = 0, req_write = 0, req_hi = 0, irdy_in = 0;
  logic [1:0] req_len_m1 = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] wr_data_in = 0;
  logic gnt_out, trdy_out, mem_we_out;
  logic [2:0] st_out;
  logic [DW-1:0] rd_data_out, mem_wdata_out;
  logic [DW/8-1:0] rd_be_out;
  logic [AW-1:0] mem_waddr_out;

  always #2 clk = ~clk;  // 250 MHz

  split_txn_sched #(.DEPTH(DEPTH), .RD_LAT(LAT), .AW(AW), .DW(DW)) dut_i (.*);

  int n_chk = 0, n_fail = 0, stepn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [15:0] a);
    logic [31:0] x;
    x = {16'h0, a};
    return (x * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // bench model
  logic [15:0] mq_addr [4][$];
  int mq_len [4][$];
  int age [4];
  int gcount [4];
  int gseq [$];
  int last_gnt_step = -1;
  bit in_phase = 0, start_next = 0, pend_we = 0;
  int ph_q, ph_len, ph_beat;
  logic [15:0] ph_addr, pend_addr;
  logic [31:0] pend_data;
  int dropped = 0;

  // stimulus for the coming edge
  bit d_pipe = 0, d_wr = 0, d_hi = 0;
  int d_len = 1;
  logic [15:0] d_addr = 0;
  int irdy_mode = 0;  // 0 random, 1 low, 2 high

  function automatic int prio_pos(input int q);
    case (q) 1: return 0; 3: return 1; 0: return 2; default: return 3; endcase
  endfunction

  task automatic monitor();
    int order [4] = '{1, 3, 0, 2};
    for (int q = 0; q < 4; q++) age[q] = (mq_addr[q].size() == 0) ? 0 : age[q] + 1;
    // R10 write commit
    chk(mem_we_out == pend_we, "R10", "mem_we", mem_we_out, pend_we);
    if (pend_we) begin
      chk(mem_waddr_out == pend_addr, "R10", "waddr", mem_waddr_out, pend_addr);
      chk(mem_wdata_out == pend_data, "R10", "wdata", mem_wdata_out, pend_data);
    end
    // R7/R11 phase framing
    chk(trdy_out == in_phase, "R7", "trdy", trdy_out, in_phase);
    if (in_phase && ph_q < 2) begin
      if (ph_beat < ph_len) begin
        chk(rd_be_out == 4'hF, "R7", "read be", rd_be_out, 4'hF);
        chk(rd_data_out == exp_word(ph_addr + 16'(ph_beat)), "R7", "read data",
            rd_data_out, exp_word(ph_addr + 16'(ph_beat)));
      end else begin
        chk(rd_be_out == 0 && rd_data_out == 0, "R9", "pad beat", rd_be_out, 0);
      end
    end else if (!in_phase) begin
      chk(rd_be_out == 0, "R9", "be outside phase", rd_be_out, 0);
    end
    if (gnt_out) begin
      int q;
      q = int'(st_out[1:0]);
      chk(!in_phase, "R11", "grant during phase", 1, 0);
      chk(st_out[2] == 1'b0, "R2", "status bit2", st_out, {1'b0, st_out[1:0]});
      chk(mq_addr[q].size() > 0, "R2", "grant for empty queue", q, -1);
      for (int k = 0; k < prio_pos(q); k++) begin
        int hq;
        hq = order[k];
        if (mq_addr[hq].size() > 0 && age[hq] >= ((hq >= 2) ? 3 : LAT + 3))
          chk(0, "R6", "higher queue passed over", q, hq);
      end
      if (mq_addr[q].size() > 0) begin
        ph_addr = mq_addr[q].pop_front();
        ph_len  = mq_len[q].pop_front();
      end
      age[q] = 0;
      ph_q = q;
      gcount[q]++;
      gseq.push_back(q);
      last_gnt_step = stepn;
      start_next = 1;
    end else begin
      chk(st_out == 3'b111, "R2", "idle status", st_out, 3'b111);
    end
  endtask

  task automatic drive();
    irdy_in    = (irdy_mode == 1) ? 1'b0 : (irdy_mode == 2) ? 1'b1 : ($urandom % 10 < 7);
    wr_data_in = $urandom;
    pend_we = 0;
    if (in_phase) begin
      if (ph_beat < 2 || irdy_in) begin
        if (ph_q >= 2 && ph_beat < ph_len) begin
          pend_we   = 1;
          pend_addr = ph_addr + 16'(ph_beat);
          pend_data = wr_data_in;
        end
        ph_beat++;
        if (ph_beat == 4) in_phase = 0;
      end
    end
    if (start_next) begin
      in_phase = 1;
      ph_beat = 0;
      start_next = 0;
    end
    pipe_in = d_pipe; req_write = d_wr; req_hi = d_hi;
    req_len_m1 = 2'(d_len - 1); req_addr = d_addr;
    if (d_pipe && rst_n) begin
      int q;
      q = {d_wr, d_hi};
      if (mq_addr[q].size() < DEPTH) begin
        mq_addr[q].push_back(d_addr);
        mq_len[q].push_back(d_len);
      end else dropped++;
    end
    d_pipe = 0;
  endtask

  task automatic step();
    @(negedge clk);
    stepn++;
    if (rst_n) monitor();
    drive();
  endtask

  task automatic push(input bit wr, input bit hi, input int len, input logic [15:0] a);
    d_pipe = 1; d_wr = wr; d_hi = hi; d_len = len; d_addr = a;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int s0, g0;
    void'($urandom(32'h1234));
    repeat (4) step();
    chk(gnt_out == 0 && trdy_out == 0 && mem_we_out == 0 && rd_be_out == 0 && st_out == 3'b111,
        "R1", "outputs in reset", {gnt_out, trdy_out, mem_we_out, st_out}, 3'b111);
    @(negedge clk); rst_n = 1;
    #1;
    chk(gnt_out == 0 && trdy_out == 0 && st_out == 3'b111, "R1", "after reset",
        {gnt_out, trdy_out, st_out}, 3'b111);
    irdy_mode = 2;

    // R5 read latency on an idle empty block
    push(0, 0, 4, 16'h0100); s0 = stepn;
    while (last_gnt_step < s0 && stepn < s0 + 50) step();
    chk(last_gnt_step - s0 == LAT + 2, "R5", "read grant delay", last_gnt_step - s0, LAT + 2);
    repeat (10) step();
    // R5 write latency
    push(1, 1, 2, 16'h0200); s0 = stepn;
    while (last_gnt_step < s0 && stepn < s0 + 50) step();
    chk(last_gnt_step - s0 == 2, "R5", "write grant delay", last_gnt_step - s0, 2);
    repeat (10) step();

    // R6 priority order behind a stalled phase (R8 stall)
    irdy_mode = 1;
    push(1, 1, 4, 16'h0300);
    repeat (6) step();
    gseq.delete();
    push(0, 0, 1, 16'h1000);
    push(1, 0, 3, 16'h2000);
    push(0, 1, 2, 16'h3000);
    push(1, 1, 4, 16'h4000);
    repeat (LAT + 6) step();
    chk(gseq.size() == 0, "R8", "grant while third beat stalled", gseq.size(), 0);
    irdy_mode = 2;
    repeat (40) step();
    chk(gseq.size() == 4, "R6", "grant count", gseq.size(), 4);
    if (gseq.size() == 4) begin
      chk(gseq[0] == 1, "R6", "first", gseq[0], 1);
      chk(gseq[1] == 3, "R6", "second", gseq[1], 3);
      chk(gseq[2] == 0, "R6", "third", gseq[2], 0);
      chk(gseq[3] == 2, "R6", "fourth", gseq[3], 2);
    end

    // R3 overflow of one queue, R4 order
    irdy_mode = 1;
    push(1, 1, 4, 16'h0500);
    repeat (4) step();
    g0 = gcount[2]; dropped = 0;
    for (int i = 0; i < DEPTH + 2; i++) push(1, 0, 1 + i % 4, 16'h5000 + 16'(i * 16));
    chk(dropped == 2, "R3", "bench drop count", dropped, 2);
    irdy_mode = 2;
    repeat (80) step();
    chk(gcount[2] - g0 == DEPTH, "R3", "grants for full queue", gcount[2] - g0, DEPTH);

    // random traffic
    irdy_mode = 0;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 10 < 4) begin
        d_pipe = 1; d_wr = $urandom % 2; d_hi = $urandom % 2;
        d_len = 1 + $urandom % 4; d_addr = 16'($urandom);
      end
      step();
    end
    irdy_mode = 2;
    repeat (300) step();
    for (int q = 0; q < 4; q++)
      chk(mq_addr[q].size() == 0, "R4", "queue drained", mq_addr[q].size(), 0);
    chk(gnt_out == 0 && trdy_out == 0, "R11", "idle at end", {gnt_out, trdy_out}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule